// File: doc/BRIEF.md
# Three-Channel Doorbell Mailbox

This block lets two processors nudge each other through three independent channels. Each channel owns one 32-bit word in which every bit is a separate doorbell. The sender raises bits through a write-1-to-set view. The receiver lowers bits through a write-1-to-clear view. Either side can read the word through a read-only view. Because setting and clearing go through their own views, no read-modify-write sequence is ever needed.

A channel's interrupt output is active while any bit of its word is set. There is no hardware acknowledgement back to the sender. A sender that wants to know that a message was consumed polls the word until the receiver has cleared the bits it rang.

The channels are indexed 0, 1 and 2: a low-priority non-secure channel, a high-priority non-secure channel, and a secure channel. The secure channel only accepts secure APB accesses, so non-secure software cannot observe it or disturb it. The register block sits in a 4 KB window and runs on the APB clock, with a synchronous active-high reset.

Top module: `dbm_top`

## Requirements
- R1: There are three channels with separate interrupt outputs, `irq[0]`, `irq[1]` and `irq[2]`. The channel bases are 0x000 for channel 0, 0x020 for channel 1 and 0x200 for channel 2, and a write to one channel leaves the other channels' words unchanged.
- R2: A read at base+0x00 returns that channel's current 32-bit word.
- R3: A write at base+0x08 sets every bit that is 1 in PWDATA. Bits written as 0 keep their value.
- R4: A write at base+0x10 clears every bit that is 1 in PWDATA. Bits written as 0 keep their value.
- R5: `irq[i]` equals the OR of all 32 bits of channel i's word as it stood one clock earlier.
- R6: Reads at base+0x08, at base+0x10 and at any unmapped address return zero with PSLVERR low. Writes to unmapped addresses change no word.
- R7: For a non-secure access (PPROT[1]=1) to channel 2, the channel ignores a write, a read returns zero, and PSLVERR is 1 in the access phase.
- R8: Secure accesses (PPROT[1]=0) to channel 2, and accesses of either kind to channels 0 and 1, behave as in R2 to R4, with PSLVERR low.
- R9: Every transfer completes with zero wait states, because PREADY is always 1.
- R10: After reset all words are zero, all interrupts are deasserted, and PRDATA and PSLVERR are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | APB peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | Byte address within the 4 KB window |
| pwdata | input | 32 | Write data |
| pprot | input | 3 | Protection attributes; bit 1 set means non-secure |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Transfer ready, always 1 |
| pslverr | output | 1 | Error for a non-secure access to the secure channel |
| irq | output | 3 | Per-channel interrupt, one bit per channel |

## Verification
The bench builds the block with the default parameters: three channels, 32-bit words, a 12-bit address and channel 2 as the secure channel. With these values the high base of the secure channel and the most significant doorbell bit are both exercised. The same values also let the bench exercise the secure-blocked path for writes, reads, sets and clears, and confirm that a blocked write leaves an existing word intact. A behavioural model of the three words and their delayed interrupts is updated on every clock edge and compared against `irq` and `pready` on every clock.

// File: rtl/dbm_pkg.sv
package dbm_pkg;

  typedef enum logic [1:0] {
    VIEW_NONE = 2'd0,
    VIEW_STAT = 2'd1,
    VIEW_SET  = 2'd2,
    VIEW_CLR  = 2'd3
  } view_e;

  localparam int unsigned OFS_STAT   = 32'h00;
  localparam int unsigned OFS_SET    = 32'h08;
  localparam int unsigned OFS_CLR    = 32'h10;
  localparam int unsigned BASE_STEP  = 32'h20;
  localparam int unsigned SECURE_BASE = 32'h200;

  // Non-secure channels are packed at BASE_STEP; the secure one sits apart.
  function automatic int unsigned chan_base(int unsigned idx, int unsigned sec_idx);
    if (idx == sec_idx) return SECURE_BASE;
    return idx * BASE_STEP;
  endfunction

endpackage

// File: rtl/dbm_decode.sv
module dbm_decode
  import dbm_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int N_CH      = 3,
  parameter int SECURE_CH = 2,
  localparam int CH_W     = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [CH_W-1:0]   ch_idx,
  output view_e             view
);

  always_comb begin
    hit    = 1'b0;
    ch_idx = '0;
    view   = VIEW_NONE;
    for (int i = 0; i < N_CH; i++) begin
      if (addr == ADDR_W'(chan_base(i, SECURE_CH) + OFS_STAT)) begin
        hit = 1'b1; ch_idx = CH_W'(i); view = VIEW_STAT;
      end
      if (addr == ADDR_W'(chan_base(i, SECURE_CH) + OFS_SET)) begin
        hit = 1'b1; ch_idx = CH_W'(i); view = VIEW_SET;
      end
      if (addr == ADDR_W'(chan_base(i, SECURE_CH) + OFS_CLR)) begin
        hit = 1'b1; ch_idx = CH_W'(i); view = VIEW_CLR;
      end
    end
  end

endmodule

// File: rtl/dbm_channel.sv
module dbm_channel #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] set_mask,
  input  logic [DATA_W-1:0] clr_mask,
  output logic [DATA_W-1:0] status,
  output logic              irq
);

  logic [DATA_W-1:0] status_q;
  logic              irq_q;

  // Set is applied after clear, so a set wins on a shared bit.
  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_mask) | set_mask;
      irq_q    <= |status_q;
    end
  end

  assign status = status_q;
  assign irq    = irq_q;

  // R3: bits rung through the set view are present afterwards
  assert_set_lands_R3: assert property (@(posedge clk) disable iff (rst)
    (set_mask != '0) |=> ((status_q & $past(set_mask)) == $past(set_mask)));

  // R4: cleared bits that were not also set are gone afterwards
  assert_clr_lands_R4: assert property (@(posedge clk) disable iff (rst)
    (clr_mask != '0) |=> ((status_q & $past(clr_mask) & ~$past(set_mask)) == '0));

  // R5: an interrupt only rises after the word held a set bit
  assert_irq_rise_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(status_q != '0));

  // R5: an empty word drops the interrupt on the next clock
  assert_irq_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (status_q == '0) |=> !irq_q);

endmodule

// File: rtl/dbm_top.sv
module dbm_top
  import dbm_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int N_CH      = 3,
  parameter int SECURE_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [2:0]        pprot,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  output logic [N_CH-1:0]   irq
);

  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1;

  logic            hit;
  logic [CH_W-1:0] ch_idx;
  view_e           view;

  dbm_decode #(
    .ADDR_W    (ADDR_W),
    .N_CH      (N_CH),
    .SECURE_CH (SECURE_CH)
  ) u_decode (
    .addr   (paddr),
    .hit    (hit),
    .ch_idx (ch_idx),
    .view   (view)
  );

  logic setup_ph, access_ph, nonsec, blocked, wr_ok;

  assign setup_ph  = psel & ~penable;
  assign access_ph = psel & penable;
  assign nonsec    = pprot[1];
  assign blocked   = hit && (ch_idx == CH_W'(SECURE_CH)) && nonsec;
  assign wr_ok     = access_ph && pwrite && hit && !blocked;

  logic [DATA_W-1:0] status_w [N_CH];
  logic [DATA_W-1:0] rd_sel;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic [DATA_W-1:0] set_m, clr_m;

    assign set_m = (wr_ok && ch_idx == CH_W'(g) && view == VIEW_SET) ? pwdata : '0;
    assign clr_m = (wr_ok && ch_idx == CH_W'(g) && view == VIEW_CLR) ? pwdata : '0;

    dbm_channel #(.DATA_W(DATA_W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .set_mask (set_m),
      .clr_mask (clr_m),
      .status   (status_w[g]),
      .irq      (irq[g])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < N_CH; i++)
      if (ch_idx == CH_W'(i)) rd_sel = status_w[i];
  end

  // Response is captured in the setup phase so it is registered yet ready
  // in the access phase; it returns to zero when the transfer completes.
  logic [DATA_W-1:0] prdata_q;
  logic              pslverr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prdata_q  <= '0;
      pslverr_q <= 1'b0;
    end else if (setup_ph) begin
      prdata_q  <= (hit && !blocked && !pwrite && view == VIEW_STAT) ? rd_sel : '0;
      pslverr_q <= blocked;
    end else if (access_ph) begin
      prdata_q  <= '0;
      pslverr_q <= 1'b0;
    end
  end

  assign prdata  = prdata_q;
  assign pslverr = pslverr_q;
  assign pready  = 1'b1;

  // R7: a blocked write leaves the secure word untouched
  assert_secure_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (access_ph && pwrite && blocked) |=> $stable(status_w[SECURE_CH]));

  // R7: a blocked access flags an error and exposes nothing
  assert_secure_resp_R7: assert property (@(posedge clk) disable iff (rst)
    (access_ph && $past(setup_ph) && blocked) |-> (pslverr && prdata == '0));

  // R8: a legal access never reports an error
  assert_no_err_R8: assert property (@(posedge clk) disable iff (rst)
    (access_ph && $past(setup_ph) && !blocked) |-> !pslverr);

  // R6: write-only views never return data
  assert_wo_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (access_ph && $past(setup_ph) && (view == VIEW_SET || view == VIEW_CLR)) |-> (prdata == '0));

  // R9: no wait states
  assert_ready_R9: assert property (@(posedge clk) disable iff (rst) pready);

endmodule

// File: tb/dbm_top_tb.sv
module dbm_top_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [2:0]  pprot = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [2:0]  irq;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dbm_top u_dut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .pprot(pprot), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .irq(irq)
  );

  // Behavioural reference: three words and their one-cycle-late interrupts.
  logic [31:0] st_m [3];
  logic [2:0]  irq_m;

  function automatic int addr_chan(input logic [11:0] a);
    if (a == 12'h000 || a == 12'h008 || a == 12'h010) return 0;
    if (a == 12'h020 || a == 12'h028 || a == 12'h030) return 1;
    if (a == 12'h200 || a == 12'h208 || a == 12'h210) return 2;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 3; c++) st_m[c] = '0;
      irq_m = '0;
    end else begin
      int c;
      for (int k = 0; k < 3; k++) irq_m[k] = (st_m[k] != 0);
      c = addr_chan(paddr);
      if (psel && penable && pwrite && c >= 0 && !(c == 2 && pprot[1])) begin
        if (paddr[4:0] == 5'h08) st_m[c] = st_m[c] | pwdata;
        if (paddr[4:0] == 5'h10) st_m[c] = st_m[c] & ~pwdata;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Per-clock comparison of interrupts (R5, R1) and ready (R9).
  always @(negedge clk) begin
    if (!rst) begin
      check("R5 irq vs model", {29'd0, irq}, {29'd0, irq_m});
      check("R9 pready", {31'd0, pready}, 32'd1);
    end
  end

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d, input logic ns,
                        input logic exp_err, input string req);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d; pprot = {1'b0, ns, 1'b0};
    @(negedge clk);
    penable = 1;
    #1 check(req, {31'd0, pslverr}, {31'd0, exp_err});
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [11:0] a, input logic ns, input logic [31:0] exp,
                        input logic exp_err, input string req);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 0; paddr = a; pprot = {1'b0, ns, 1'b0};
    @(negedge clk);
    penable = 1;
    #1;
    check(req, prdata, exp);
    check(req, {31'd0, pslverr}, {31'd0, exp_err});
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  initial begin : watchdog
    #400000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R10: reset state
    check("R10 prdata", prdata, 0);
    check("R10 pslverr", {31'd0, pslverr}, 0);
    check("R10 irq", {29'd0, irq}, 0);
    apb_rd(12'h000, 1, 0, 0, "R10 ch0 word");
    apb_rd(12'h200, 0, 0, 0, "R10 ch2 word");

    // R3, R2: set bits on channel 0
    apb_wr(12'h008, 32'h0000_0005, 1, 0, "R3 set err");
    apb_rd(12'h000, 1, 32'h0000_0005, 0, "R2 ch0 after set");
    apb_wr(12'h008, 32'h0000_0010, 1, 0, "R3 set err");
    apb_rd(12'h000, 1, 32'h0000_0015, 0, "R3 zeros keep bits");
    // R4: clear
    apb_wr(12'h010, 32'h0000_0004, 1, 0, "R4 clr err");
    apb_rd(12'h000, 1, 32'h0000_0011, 0, "R4 ch0 after clear");
    // R1: channel 1 independent, MSB doorbell
    apb_wr(12'h028, 32'h8000_0000, 1, 0, "R1 set ch1");
    apb_rd(12'h020, 1, 32'h8000_0000, 0, "R1 ch1 word");
    apb_rd(12'h000, 1, 32'h0000_0011, 0, "R1 ch0 untouched");
    check("R1 irq ch0 ch1", {29'd0, irq}, 32'd3);

    // R6: write-only views and unmapped addresses
    apb_rd(12'h008, 1, 0, 0, "R6 set view read");
    apb_rd(12'h030, 1, 0, 0, "R6 clr view read");
    apb_rd(12'h100, 1, 0, 0, "R6 unmapped read");
    apb_wr(12'h104, 32'hFFFF_FFFF, 1, 0, "R6 unmapped write");
    apb_rd(12'h020, 1, 32'h8000_0000, 0, "R6 ch1 after unmapped write");

    // R7: non-secure access to the secure channel
    apb_wr(12'h208, 32'h0000_00FF, 1, 1, "R7 ns set err");
    apb_rd(12'h200, 0, 0, 0, "R7 ns set ignored");
    check("R7 irq2 quiet", {31'd0, irq[2]}, 0);
    // R8: secure access works
    apb_wr(12'h208, 32'h0000_00A5, 0, 0, "R8 s set");
    apb_rd(12'h200, 0, 32'h0000_00A5, 0, "R8 s read");
    apb_rd(12'h200, 1, 0, 1, "R7 ns read hidden");
    apb_wr(12'h210, 32'hFFFF_FFFF, 1, 1, "R7 ns clear err");
    apb_rd(12'h200, 0, 32'h0000_00A5, 0, "R7 ns clear ignored");
    check("R8 irq2 up", {31'd0, irq[2]}, 1);
    apb_wr(12'h210, 32'h0000_00A5, 0, 0, "R8 s clear");
    apb_rd(12'h200, 0, 0, 0, "R8 s cleared");

    // R4, R5: drain all, interrupts fall
    apb_wr(12'h010, 32'hFFFF_FFFF, 1, 0, "R4 clr all ch0");
    apb_wr(12'h030, 32'hFFFF_FFFF, 0, 0, "R4 clr all ch1");
    repeat (2) @(negedge clk);
    check("R5 irq all low", {29'd0, irq}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule